// File: doc/BRIEF.md
# Paged DMA Address Translator

This block sits between DMA channels and system memory. It turns a 32-bit device-side address into a physical address by fetching one entry from a translation table kept in memory. A channel presents an address on a valid/ready request port. The block splits the address into a 4 KiB page number and a byte offset, and checks the page number against the programmed table length. When the page is inside the table, the block reads the matching entry through a valid/ready memory read port. It then returns the physical page frame from that entry with the original offset attached.

Each table entry is 8 bytes. The low 32-bit word holds the frame and the high word carries nothing used here. Software programs two registers: the table start address and the table length in bytes. A page outside the table, or an entry read that reports an error, gives a response with no access rights and a zero address rather than a bus error. The response stays on the port until the requester takes it, and the block works on only one lookup at a time.

Top module: `dma_page_xlate`

## Requirements
- R1: After reset the table start and table length registers are zero, `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0. Any lookup made before the registers are programmed therefore faults.
- R2: The page number is `req_addr[31:12]` and the offset is `req_addr[11:0]`. A lookup is inside the table only when the page number is strictly less than the table length (bytes) shifted right by 3. A length that is not a multiple of 8 is rounded down to whole entries.
- R3: A page outside the table produces a response with `rsp_perm`=0 and `rsp_addr`=0, and no memory read is issued.
- R4: The entry read address is the table start with bit 31 forced to 0, plus the page number times 8, taken modulo 2^32.
- R5: For a good lookup, `rsp_addr` = {`mem_rsp_data[31:12]`, `req_addr[11:0]`}. Bits 11:0 of the frame word and the whole upper word `mem_rsp_data[63:32]` have no effect.
- R6: A good lookup answers with `rsp_perm`=1, which grants both read and write access.
- R7: An entry read that returns with `mem_rsp_err`=1 produces `rsp_perm`=0 and `rsp_addr`=0.
- R8: `mem_rd_valid` stays high and `mem_rd_addr` stays stable until `mem_rd_ready` is seen.
- R9: `rsp_valid`, `rsp_addr` and `rsp_perm` hold until `rsp_ready`. `req_ready` stays low from acceptance until the response is taken.
- R10: `cfg_sel`=0 writes the table start and `cfg_sel`=1 writes the table length. A write in the same cycle a request is accepted does not affect that request; it applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0: table start, 1: table length in bytes |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | 32 | Device-side address to translate |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_addr | output | 32 | Translated physical address, 0 on fault |
| rsp_perm | output | 1 | 1: read and write granted, 0: no access |
| mem_rd_valid | output | 1 | Entry read request valid |
| mem_rd_ready | input | 1 | Memory accepts the entry read |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry: frame in [31:0], [63:32] unused |
| mem_rsp_err | input | 1 | Entry read failed |

## Verification
A register write can land in the same cycle as a request is accepted, so a reprogramming of the table and a lookup meet on one clock edge. The bench provokes this by raising `cfg_we`, which shrinks the table length to zero, in the same cycle as `req_valid` on an in-range page. It expects that lookup to complete with full rights from the old limit and the next lookup to fault under the new one. Memory stalls and a delayed `rsp_ready` are also overlapped with the lookup. In those cases the bench judges whether the read address and the response stay put and whether `req_ready` stays low.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned XL_ADDR_W     = 32;
  localparam int unsigned XL_PAGE_BITS  = 12;
  localparam int unsigned XL_ENTRY_LOG2 = 3;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_FETCH = 2'd1,
    XS_WAIT  = 2'd2,
    XS_RESP  = 2'd3
  } xlate_state_e;
endpackage

// File: rtl/xlate_cfg_regs.sv
module xlate_cfg_regs #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] tbl_base,
  output logic [AW-1:0] tbl_len
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl_base <= '0;
      tbl_len  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) tbl_len  <= cfg_wdata;
      else         tbl_base <= cfg_wdata;
    end
  end
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
  import xlate_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned PB   = 12,
  parameter int unsigned EL2  = 3,
  localparam int unsigned MW  = 8 << EL2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] tbl_len,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_perm,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [MW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          acc_evt,
  output logic          oob_evt
);
  function automatic logic [AW-1:0] page_num(input logic [AW-1:0] a);
    return a >> PB;
  endfunction

  function automatic logic inside_table(input logic [AW-1:0] pg,
                                        input logic [AW-1:0] len_bytes);
    return pg < (len_bytes >> EL2);
  endfunction

  function automatic logic [AW-1:0] entry_loc(input logic [AW-1:0] base,
                                              input logic [AW-1:0] pg);
    return {1'b0, base[AW-2:0]} + (pg << EL2);
  endfunction

  function automatic logic [AW-1:0] join_frame(input logic [AW-1:0] frame,
                                               input logic [PB-1:0] off);
    return {frame[AW-1:PB], off};
  endfunction

  xlate_state_e state_q;
  logic [PB-1:0] off_q;
  logic [AW-1:0] ent_q;
  logic [AW-1:0] res_addr_q;
  logic          res_perm_q;

  logic [AW-1:0] pg_w;
  logic          hit_w;

  assign pg_w    = page_num(req_addr);
  assign hit_w   = inside_table(pg_w, tbl_len);
  assign acc_evt = req_valid && req_ready;
  assign oob_evt = acc_evt && !hit_w;

  assign req_ready    = (state_q == XS_IDLE);
  assign mem_rd_valid = (state_q == XS_FETCH);
  assign rsp_valid    = (state_q == XS_RESP);
  assign mem_rd_addr  = ent_q;
  assign rsp_addr     = res_addr_q;
  assign rsp_perm     = res_perm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= XS_IDLE;
      off_q      <= '0;
      ent_q      <= '0;
      res_addr_q <= '0;
      res_perm_q <= 1'b0;
    end else begin
      unique case (state_q)
        XS_IDLE: if (acc_evt) begin
          off_q <= req_addr[PB-1:0];
          if (hit_w) begin
            ent_q   <= entry_loc(tbl_base, pg_w);
            state_q <= XS_FETCH;
          end else begin
            res_addr_q <= '0;
            res_perm_q <= 1'b0;
            state_q    <= XS_RESP;
          end
        end
        XS_FETCH: if (mem_rd_ready) state_q <= XS_WAIT;
        XS_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            res_addr_q <= '0;
            res_perm_q <= 1'b0;
          end else begin
            res_addr_q <= join_frame(mem_rsp_data[AW-1:0], off_q);
            res_perm_q <= 1'b1;
          end
          state_q <= XS_RESP;
        end
        XS_RESP: if (rsp_ready) state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_page_xlate.sv
module dma_page_xlate
  import xlate_pkg::*;
#(
  parameter int unsigned AW  = XL_ADDR_W,
  parameter int unsigned PB  = XL_PAGE_BITS,
  parameter int unsigned EL2 = XL_ENTRY_LOG2,
  localparam int unsigned MW = 8 << EL2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_perm,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [MW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err
);
  logic [AW-1:0] tbl_base;
  logic [AW-1:0] tbl_len;
  logic          acc_evt;
  logic          oob_evt;

  xlate_cfg_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .tbl_base  (tbl_base),
    .tbl_len   (tbl_len)
  );

  xlate_seq #(.AW(AW), .PB(PB), .EL2(EL2)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tbl_base      (tbl_base),
    .tbl_len       (tbl_len),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_addr      (rsp_addr),
    .rsp_perm      (rsp_perm),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err),
    .acc_evt       (acc_evt),
    .oob_evt       (oob_evt)
  );
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [AW-1:0] rsp_addr,
  input logic          rsp_perm,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic          acc_evt,
  input logic          oob_evt
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!rsp_valid && !mem_rd_valid && req_ready));

  p_oob_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oob_evt |=> (rsp_valid && !rsp_perm && rsp_addr == '0 && !mem_rd_valid));

  p_noperm_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_perm) |-> (rsp_addr == '0));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_perm)));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_valid) |-> !req_ready);

  p_accept_leaves_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> !req_ready);
endmodule

bind dma_page_xlate xlate_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_addr     (rsp_addr),
  .rsp_perm     (rsp_perm),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .acc_evt      (acc_evt),
  .oob_evt      (oob_evt)
);

// File: tb/tb_dma_page_xlate.sv
module tb_dma_page_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_perm;
  logic [31:0] rsp_addr;
  logic        mem_rd_valid, mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int checks = 0, failures = 0;
  logic [31:0] base_m = '0, len_m = '0;
  int stall_cfg = 0, wait_ctr = 0;
  logic err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int hs_cnt = 0, served_cnt = 0;
  logic [31:0] cap_addr = '0;

  always #2 clk = ~clk;

  dma_page_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_perm(rsp_perm),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
  );

  function automatic logic [31:0] frame_of(input logic [31:0] a);
    return a * 32'h0001_3579 + 32'h0000_0ABC;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: handshake capture on the edge, responses driven mid-cycle
  always @(posedge clk) begin
    if (mem_rd_valid && mem_rd_ready) begin
      cap_addr <= mem_rd_addr;
      hs_cnt   <= hs_cnt + 1;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (hs_cnt != served_cnt) begin
        mem_rd_ready  = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = {~cap_addr, frame_of(cap_addr)};
        mem_rsp_err   = err_en && (cap_addr == err_addr);
        served_cnt++;
        wait_ctr = 0;
      end else begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        if (mem_rd_valid && !mem_rd_ready) begin
          if (wait_ctr < stall_cfg) wait_ctr++;
          else mem_rd_ready = 1'b1;
        end
      end
    end
  end

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) len_m = d; else base_m = d;
  endtask

  // waits for the response, holds it, and judges it
  task automatic finish(input logic [31:0] a, input bit exp_perm,
                        input logic [31:0] exp_addr, input logic [31:0] exp_fetch,
                        input bit exp_read, input int reads0, input int hold,
                        input string tag);
    int  n = 0;
    bit  addr_bad = 0, busy_bad = 0, hold_bad = 0;
    logic [31:0] first_fetch = '0;
    bit  seen = 0;
    while (!rsp_valid && n < 200) begin
      if (req_ready) busy_bad = 1;
      if (mem_rd_valid) begin
        if (!seen) begin first_fetch = mem_rd_addr; seen = 1; end
        if (mem_rd_addr != first_fetch || mem_rd_addr != exp_fetch) addr_bad = 1;
      end
      @(negedge clk); n++;
    end
    chk(rsp_valid, tag, "R9 response arrives", {31'd0, rsp_valid}, 32'd1);
    if (exp_read)
      chk(!addr_bad, "R4/R8", {tag, " entry read address"}, first_fetch, exp_fetch);
    chk(!busy_bad, "R9", {tag, " req_ready low while busy"}, {31'd0, busy_bad}, 32'd0);
    for (int h = 0; h < hold; h++) begin
      if (!rsp_valid || rsp_addr != exp_addr || rsp_perm != exp_perm || req_ready)
        hold_bad = 1;
      @(negedge clk);
    end
    if (hold > 0)
      chk(!hold_bad, "R9", {tag, " response held"}, {31'd0, hold_bad}, 32'd0);
    chk(rsp_perm == exp_perm, tag, "perm", {31'd0, rsp_perm}, {31'd0, exp_perm});
    chk(rsp_addr == exp_addr, tag, "addr", rsp_addr, exp_addr);
    chk((served_cnt - reads0) == (exp_read ? 1 : 0), tag, "memory reads",
        served_cnt - reads0, exp_read ? 1 : 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, tag, "idle after take", {31'd0, rsp_valid}, 32'd0);
    if (a == 32'hFFFF_FFFF) $display("unreachable");
  endtask

  task automatic lookup(input logic [31:0] a, input int hold, input int stall,
                        input bit inject_err, input string tag);
    logic [31:0] pg = a >> 12;
    bit          hit = pg < (len_m >> 3);
    logic [31:0] fetch = {1'b0, base_m[30:0]} + (pg << 3);
    logic [31:0] expa = (hit && !inject_err) ? {frame_of(fetch)[31:12], a[11:0]} : 32'd0;
    int          r0 = served_cnt;
    stall_cfg = stall; err_en = inject_err; err_addr = fetch;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    finish(a, hit && !inject_err, expa, fetch, hit, r0, hold, tag);
    err_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R1", "idle outputs after reset",
        {29'd0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);
    lookup(32'h0000_0123, 0, 0, 0, "R1 unprogrammed lookup faults");
  endtask

  task automatic t_basic();
    cfg_write(1'b0, 32'h8000_4000);   // bit 31 must be dropped
    cfg_write(1'b1, 32'h0000_0100);   // 32 entries
    lookup(32'h0000_5ABC, 0, 0, 0, "R5 R6 basic translation");
    lookup(32'h0001_0FFF, 0, 0, 0, "R4 R5 offset kept");
  endtask

  task automatic t_bounds();
    lookup(32'h0001_F123, 0, 0, 0, "R2 last entry in range");
    lookup(32'h0002_0000, 0, 0, 0, "R2 R3 first page past table");
    lookup(32'hFFFF_F001, 0, 0, 0, "R3 top page faults");
    cfg_write(1'b1, 32'h0000_010F);   // rounds down to 33 entries
    lookup(32'h0002_0777, 0, 0, 0, "R2 partial entry length, page 32");
    lookup(32'h0002_1000, 0, 0, 0, "R2 partial entry length, page 33");
  endtask

  task automatic t_stall();
    lookup(32'h0000_3456, 4, 5, 0, "R8 R9 memory stall and held response");
  endtask

  task automatic t_err();
    lookup(32'h0000_7010, 2, 1, 1, "R7 failed entry read");
    lookup(32'h0000_7010, 0, 0, 0, "R7 same page after error recovers");
  endtask

  task automatic t_wrap();
    cfg_write(1'b0, 32'hFFFF_FFF8);   // masked to 0x7FFFFFF8
    cfg_write(1'b1, 32'hFFFF_FFF8);
    lookup(32'h0000_2000, 0, 0, 0, "R4 base mask and add");
  endtask

  task automatic t_same_cycle();
    logic [31:0] a = 32'h0000_4321;
    logic [31:0] pg = a >> 12;
    logic [31:0] fetch = {1'b0, base_m[30:0]} + (pg << 3);
    logic [31:0] expa = {frame_of(fetch)[31:12], a[11:0]};
    int r0 = served_cnt;
    stall_cfg = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'd0;
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    len_m = 32'd0;
    finish(a, 1'b1, expa, fetch, 1'b1, r0, 0, "R10 old limit used by accepted request");
    lookup(a, 0, 0, 0, "R10 new limit applies afterwards");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bounds();
    t_stall();
    t_err();
    t_same_cycle();
    t_wrap();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule